// File: doc/BRIEF.md
# Maintenance Port-Write Packet Transmitter

This block lets software send one maintenance port-write packet at a time. Software writes the payload, up to 64 bytes, into a small word-wide buffer through a register-bus slave. It then programs a routing register (destination and hop count). Finally it writes a control register that holds the payload size in bytes and a launch bit.

Once the launch bit is accepted, the block composes a two-beat header. The header carries the maintenance format type, the port-write transaction type, and size fields derived from the byte count. The block then streams the payload words in buffer order on a 32-bit valid/ready packet port with start and end markers. The launch bit stays set for the whole flight and clears itself when the final beat is accepted, so software can poll it as a busy flag. While it is set, the buffer and the control and routing registers refuse writes, so the packet in flight cannot be corrupted.

Register space (byte addresses, bits [1:0] ignored):
- Control sits at 0x10200. Bit 0 is the launch bit, and bits [22:16] hold the payload size.
- Routing sits at 0x10204. Bits [15:0] hold the destination, and bits [23:16] hold the hop count.
- Payload word i sits at 0x10210 + 4*i, for i from 0 to 15.

Top module: `port_write_tx`

## Requirements
- R1: After reset the control register reads 0 and tx_valid is low.
- R2: A bus write to payload word i (byte address 0x10210 + 4*i, 0 <= i < 16) stores the word; a bus read returns register or buffer contents on bus_rdata in the cycle after bus_rd.
- R3: A control write with bit 0 set and a size in bits [22:16] between 1 and 64, made while idle, sets the launch bit; tx_valid is only ever high while the launch bit is set.
- R4: A control write with size 0 or above 64 leaves the launch bit clear and emits no packet; the size still reads back.
- R5: Header beat 0 is {4'h8 at [31:28], 4'b0100 at [27:24], wrsize at [23:20], wdptr at [19], 3'b000 at [18:16], hop count at [15:8], 8'h00 at [7:0]} and carries tx_sop.
- R6: wrsize/wdptr are 4'b1011/0 for sizes 1..8, 4'b1011/1 for 9..16, 4'b1100/0 for 17..32, 4'b1100/1 for 33..64.
- R7: Header beat 1 is {destination at [31:16], 16'h0000}.
- R8: After the header come ceil(size/4) payload beats, words 0 upward, with tx_eop only on the last one and tx_sop on no payload beat.
- R9: While tx_valid is high and tx_ready low, tx_valid, tx_data, tx_sop and tx_eop stay unchanged.
- R10: The launch bit clears on the clock edge that accepts the last payload beat, after which tx_valid is low.
- R11: While the launch bit is set, bus writes to the buffer, the control register and the routing register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Downstream accepts beat |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| tx_data | output | 32 | Beat data |

## Verification
The bench builds the block with its default values: a 64-byte buffer of sixteen words, with the size field seven bits wide. At these values a 64-byte packet uses every buffer slot. A size of 65 can still be written, so the upper rejection bound can be exercised alongside zero. Packet sizes on both sides of each wrsize/wdptr threshold (8/9, 16/17, 32/33) and sizes that do and do not fill a whole last word are sent. Back-pressure patterns are applied to cover the hold rule. Buffer and control writes are also issued during a stalled 64-byte flight.

// File: rtl/pw_tx_pkg.sv
package pw_tx_pkg;

  localparam logic [3:0] FTYPE_MAINT  = 4'h8;
  localparam logic [3:0] TTYPE_PORTWR = 4'b0100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_PAY
  } seq_state_e;

  typedef struct packed {
    logic [3:0] wrsize;
    logic       wdptr;
  } size_code_t;

  // Map a byte count onto the smallest double-word bucket that holds it.
  function automatic size_code_t encode_size(input logic [7:0] nbytes);
    size_code_t c;
    if (nbytes <= 8'd8) begin
      c.wrsize = 4'b1011; c.wdptr = 1'b0;
    end else if (nbytes <= 8'd16) begin
      c.wrsize = 4'b1011; c.wdptr = 1'b1;
    end else if (nbytes <= 8'd32) begin
      c.wrsize = 4'b1100; c.wdptr = 1'b0;
    end else begin
      c.wrsize = 4'b1100; c.wdptr = 1'b1;
    end
    return c;
  endfunction

endpackage

// File: rtl/pw_tx_buf.sv
module pw_tx_buf #(
  parameter int WORDS = 16,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [31:0]      rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [31:0]      rdata_b
);

  logic [31:0] mem [WORDS];

  // Storage only; write gating is decided by the register slave.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/pw_tx_regs.sv
module pw_tx_regs #(
  parameter int          ADDR_W     = 20,
  parameter int          MAX_BYTES  = 64,
  parameter logic [19:0] CTRL_ADDR  = 20'h10200,
  parameter logic [19:0] ROUTE_ADDR = 20'h10204,
  parameter logic [19:0] BUF_BASE   = 20'h10210,
  localparam int WORDS  = MAX_BYTES / 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int SIZE_W = $clog2(MAX_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  input  logic [31:0]       buf_rdata,
  input  logic              done,
  output logic              launch,
  output logic [SIZE_W-1:0] size,
  output logic [15:0]       dest,
  output logic [7:0]        hop
);

  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] CTRL_W  = CTRL_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ROUTE_W = ROUTE_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] BUF_W   = BUF_BASE[ADDR_W-1:2];
  localparam logic [WA_W-1:0] WORDS_W = WA_W'(WORDS);

  logic [WA_W-1:0]   waddr, woff;
  logic              ctrl_hit, route_hit, buf_hit;
  logic [SIZE_W-1:0] size_w;
  logic              size_ok;

  logic              ready_q, ready_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [15:0]       dest_q, dest_d;
  logic [7:0]        hop_q, hop_d;
  logic [31:0]       rdata_q, rdata_d;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16+SIZE_W], bus_wdata[15:1]};

  // Address decode
  assign waddr     = bus_addr[ADDR_W-1:2];
  assign woff      = waddr - BUF_W;
  assign ctrl_hit  = (waddr == CTRL_W);
  assign route_hit = (waddr == ROUTE_W);
  assign buf_hit   = (waddr >= BUF_W) && (woff < WORDS_W);
  assign buf_idx   = woff[IDX_W-1:0];

  assign size_w  = bus_wdata[16 +: SIZE_W];
  assign size_ok = (size_w != '0) && (size_w <= SIZE_W'(MAX_BYTES));

  // Buffer is frozen for the whole flight
  assign buf_we = bus_wr && buf_hit && !ready_q;

  // Next-state
  always_comb begin
    ready_d = ready_q;
    size_d  = size_q;
    dest_d  = dest_q;
    hop_d   = hop_q;
    rdata_d = rdata_q;

    if (done) begin
      ready_d = 1'b0;
    end else if (bus_wr && !ready_q) begin
      if (ctrl_hit) begin
        size_d  = size_w;
        ready_d = bus_wdata[0] && size_ok;
      end
      if (route_hit) begin
        dest_d = bus_wdata[15:0];
        hop_d  = bus_wdata[23:16];
      end
    end

    if (bus_rd) begin
      rdata_d = '0;
      if (ctrl_hit) begin
        rdata_d[0]             = ready_q;
        rdata_d[16 +: SIZE_W]  = size_q;
      end else if (route_hit) begin
        rdata_d = {8'h00, hop_q, dest_q};
      end else if (buf_hit) begin
        rdata_d = buf_rdata;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      size_q  <= '0;
      dest_q  <= '0;
      hop_q   <= '0;
      rdata_q <= '0;
    end else begin
      ready_q <= ready_d;
      size_q  <= size_d;
      dest_q  <= dest_d;
      hop_q   <= hop_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign launch    = ready_q;
  assign size      = size_q;
  assign dest      = dest_q;
  assign hop       = hop_q;

  // Bad sizes never arm the launch bit
  assert_reject_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ctrl_hit && !ready_q && !size_ok) |=> !ready_q);

  // Armed launch persists until the sequencer reports completion
  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !done) |=> (ready_q && $stable(size_q) && $stable(dest_q) && $stable(hop_q)));

  // Completion drops the launch bit
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ready_q);

endmodule

// File: rtl/pw_tx_seq.sv
module pw_tx_seq
  import pw_tx_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  localparam int WORDS  = MAX_BYTES / 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int SIZE_W = $clog2(MAX_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [SIZE_W-1:0] size,
  input  logic [15:0]       dest,
  input  logic [7:0]        hop,
  input  logic [31:0]       pay_word,
  output logic [IDX_W-1:0]  pay_idx,
  output logic              done,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [31:0]       tx_data
);

  seq_state_e        state_q, state_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic [SIZE_W-1:0] nbeats;
  logic              last;
  size_code_t        code;
  logic [31:0]       hdr0, hdr1;

  assign nbeats  = (size + SIZE_W'(3)) >> 2;
  assign last    = (cnt_q == nbeats - SIZE_W'(1));
  assign pay_idx = cnt_q[IDX_W-1:0];

  assign code = encode_size(8'(size));
  assign hdr0 = {FTYPE_MAINT, TTYPE_PORTWR, code.wrsize, code.wdptr, 3'b000, hop, 8'h00};
  assign hdr1 = {dest, 16'h0000};

  // Next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (launch) begin
        state_d = ST_HDR0;
        cnt_d   = '0;
      end
      ST_HDR0: if (tx_ready) state_d = ST_HDR1;
      ST_HDR1: if (tx_ready) begin
        state_d = ST_PAY;
        cnt_d   = '0;
      end
      ST_PAY: if (tx_ready) begin
        if (last) state_d = ST_IDLE;
        else      cnt_d   = cnt_q + SIZE_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Beat outputs
  always_comb begin
    tx_valid = (state_q != ST_IDLE);
    tx_sop   = (state_q == ST_HDR0);
    tx_eop   = (state_q == ST_PAY) && last;
    unique case (state_q)
      ST_HDR0: tx_data = hdr0;
      ST_HDR1: tx_data = hdr1;
      ST_PAY:  tx_data = pay_word;
      default: tx_data = '0;
    endcase
  end

  assign done = (state_q == ST_PAY) && tx_ready && last;

  // A stalled beat must not move
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  // Output only while armed by the control register
  assert_valid_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> launch);

  // One packet per launch: nothing follows the end beat
  assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

  // Markers never coincide
  assert_marker_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

endmodule

// File: rtl/port_write_tx.sv
module port_write_tx #(
  parameter int          ADDR_W     = 20,
  parameter int          MAX_BYTES  = 64,
  parameter logic [19:0] CTRL_ADDR  = 20'h10200,
  parameter logic [19:0] ROUTE_ADDR = 20'h10204,
  parameter logic [19:0] BUF_BASE   = 20'h10210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [31:0]       tx_data
);

  localparam int WORDS  = MAX_BYTES / 4;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int SIZE_W = $clog2(MAX_BYTES) + 1;

  logic              buf_we;
  logic [IDX_W-1:0]  buf_idx, pay_idx;
  logic [31:0]       buf_rdata, pay_word;
  logic              launch, done;
  logic [SIZE_W-1:0] size;
  logic [15:0]       dest;
  logic [7:0]        hop;

  pw_tx_regs #(
    .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES),
    .CTRL_ADDR(CTRL_ADDR), .ROUTE_ADDR(ROUTE_ADDR), .BUF_BASE(BUF_BASE)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
    .done(done), .launch(launch), .size(size), .dest(dest), .hop(hop)
  );

  pw_tx_buf #(.WORDS(WORDS), .IDX_W(IDX_W)) i_buf (
    .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(bus_wdata),
    .ridx_a(buf_idx), .rdata_a(buf_rdata),
    .ridx_b(pay_idx), .rdata_b(pay_word)
  );

  pw_tx_seq #(.MAX_BYTES(MAX_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .size(size), .dest(dest), .hop(hop),
    .pay_word(pay_word), .pay_idx(pay_idx), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data)
  );

endmodule

// File: tb/test_port_write_tx.sv
module test_port_write_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_sop, tx_eop;
  logic        tx_ready = 1'b1;
  logic [31:0] tx_data;

  int checks = 0, fails = 0;
  bit stall_en = 0;
  bit finished = 0;
  logic [33:0] exp_q[$];
  logic [31:0] shadow [16];

  localparam logic [19:0] A_CTRL  = 20'h10200;
  localparam logic [19:0] A_ROUTE = 20'h10204;
  localparam logic [19:0] A_BUF   = 20'h10210;

  always #5 clk = ~clk;

  port_write_tx i_port_write_tx (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_data(tx_data)
  );

  task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // R6 size buckets, computed from the requirement
  function automatic logic [4:0] size_bucket(input int n);
    if (n <= 8)       return {4'b1011, 1'b0};
    else if (n <= 16) return {4'b1011, 1'b1};
    else if (n <= 32) return {4'b1100, 1'b0};
    else              return {4'b1100, 1'b1};
  endfunction

  // Driver: pushes the expected beats, then arms the block
  task automatic send_packet(input int n, input logic [15:0] dst, input logic [7:0] hp);
    logic [4:0] b;
    int nb;
    b = size_bucket(n);
    nb = (n + 3) / 4;
    exp_q.push_back({1'b1, 1'b0, 4'h8, 4'b0100, b[4:1], b[0], 3'b000, hp, 8'h00}); // R5 R6
    exp_q.push_back({1'b0, 1'b0, dst, 16'h0000});                                 // R7
    for (int i = 0; i < nb; i++)
      exp_q.push_back({1'b0, (i == nb - 1), shadow[i]});                           // R8
    bus_write(A_ROUTE, {8'h00, hp, dst});
    bus_write(A_CTRL, (32'(n) << 16) | 32'h1);
  endtask

  task automatic wait_drained();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Back-pressure driver, changes away from the sampling edge
  initial begin
    int rc = 0;
    forever begin
      @(posedge clk); #1;
      rc++;
      tx_ready = stall_en ? ((rc % 3) != 0 && (rc % 7) != 2) : 1'b1;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic        pv = 0, pr = 1;
    logic [33:0] pbeat = '0;
    logic [33:0] got, e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        got = {tx_sop, tx_eop, tx_data};
        if (pv && !pr)
          check(tx_valid && got == pbeat, "R9 stalled beat held", {1'b0, tx_valid, got[31:0]}, pbeat);
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0)
            check(1'b0, "R4/R8 unexpected beat", got, '0);
          else begin
            e = exp_q.pop_front();
            check(got == e, "R5/R6/R7/R8 beat", got, e);
          end
        end
        pv = tx_valid; pr = tx_ready; pbeat = got;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int sizes[10] = '{1, 4, 5, 8, 9, 16, 17, 32, 33, 64};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(tx_valid == 1'b0, "R1 tx_valid after reset", 34'(tx_valid), 34'h0);
    bus_read(A_CTRL, rd);
    check(rd == 32'h0, "R1 control after reset", 34'(rd), 34'h0);

    // R2 fill and read back the buffer
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 32'hA5000000 ^ (32'(i) * 32'h01030507);
      bus_write(A_BUF + 20'(4 * i), shadow[i]);
    end
    for (int i = 0; i < 16; i++) begin
      bus_read(A_BUF + 20'(4 * i), rd);
      check(rd == shadow[i], "R2 buffer readback", 34'(rd), 34'(shadow[i]));
    end

    // R3 R5 R6 R7 R8 R10 packets across bucket edges, with and without stalls
    for (int k = 0; k < 10; k++) begin
      stall_en = (k % 2) == 1;
      send_packet(sizes[k], 16'h1200 + 16'(k), 8'hF0 + 8'(k));
      wait_drained();
      check(exp_q.size() == 0, "R8 all beats seen", 34'(exp_q.size()), 34'h0);
      bus_read(A_CTRL, rd);
      check(rd == (32'(sizes[k]) << 16), "R10 launch bit cleared", 34'(rd), 34'(32'(sizes[k]) << 16));
    end

    // R4 size zero and size 65 rejected
    stall_en = 0;
    bus_write(A_CTRL, 32'h0000_0001);
    repeat (10) @(negedge clk);
    bus_read(A_CTRL, rd);
    check(rd == 32'h0, "R4 size 0 rejected", 34'(rd), 34'h0);
    bus_write(A_CTRL, (32'd65 << 16) | 32'h1);
    repeat (10) @(negedge clk);
    bus_read(A_CTRL, rd);
    check(rd == (32'd65 << 16), "R4 size 65 rejected", 34'(rd), 34'(32'd65 << 16));

    // R11 writes during a stalled flight are ignored
    stall_en = 1;
    send_packet(64, 16'hBEEF, 8'h3C);
    bus_write(A_BUF, 32'hDEADDEAD);
    bus_write(A_CTRL, (32'd8 << 16) | 32'h1);
    bus_write(A_ROUTE, 32'h00FF_FFFF);
    bus_read(A_CTRL, rd);
    check(rd == ((32'd64 << 16) | 32'h1), "R11 control frozen in flight", 34'(rd), 34'((32'd64 << 16) | 32'h1));
    wait_drained();
    stall_en = 0;
    bus_read(A_BUF, rd);
    check(rd == shadow[0], "R11 buffer write ignored", 34'(rd), 34'(shadow[0]));
    bus_read(A_ROUTE, rd);
    check(rd == 32'h003C_BEEF, "R11 route write ignored", 34'(rd), 34'h003C_BEEF);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0 && !tx_valid, "R10 idle after flight", 34'(tx_valid), 34'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule